// File: doc/BRIEF.md
# Register-Controlled Shifter and Flag Unit

This unit is one slice of the integer execute stage of a 32-bit core. It takes two operands, a 4-bit operation code and the current T, Q and M status flags. It returns a 32-bit result and new flag values, each with its own write enable. All outputs are registered, so results appear one clock after the operation is presented.

The unit covers the following operations:

- Two variable-distance shifts, one arithmetic and one logical. The sign of the second operand picks the direction and its low five bits give the distance.
- Five single-position shifts and rotates. Each of these exchanges one bit with the T flag.
- A compare that reports whether any byte lane of the two operands matches.
- The sign-setup step that starts a non-restoring division.

The register file writes the result only when the result enable is high. The status register takes T, Q and M only when their enables are high.

Top module: `shflag_unit`

## Requirements
- R1: Codes 0 (arithmetic) and 1 (logical) with in_b[31]=0 give in_a shifted left by in_b[4:0], with zeros filling from the bottom.
- R2: Code 0 with in_b[31]=1 and in_b[4:0]=k≠0 gives in_a shifted right by 32−k, with copies of in_a[31] filling from the top.
- R3: Codes 0 and 1 with in_b[31]=1 and in_b[4:0]=0 shift right by the full 32 positions. Code 0 then gives all ones when in_a[31]=1 and zero otherwise. Code 1 always gives zero.
- R4: Code 1 with in_b[31]=1 and in_b[4:0]=k≠0 gives in_a shifted right by 32−k, with zeros filling from the top.
- R5: Code 2 (rotate left through T) gives {in_a[30:0], in_t} and sets T to in_a[31]. Code 3 (rotate right through T) gives {in_t, in_a[31:1]} and sets T to in_a[0].
- R6: Code 4 shifts left by one and sets T to in_a[31]. Code 5 shifts right by one, keeps bit 31 and sets T to in_a[0]. Code 6 shifts right by one, fills bit 31 with zero and sets T to in_a[0].
- R7: Code 7 sets T to 1 when any of the lanes [7:0], [15:8], [23:16] and [31:24] holds the same value in in_a and in_b. It sets T to 0 otherwise. The result is in_a with no result write.
- R8: Code 8 sets Q to in_b[31], M to in_a[31] and T to Q XOR M. It raises both flag enables and does not write the result.
- R9: Codes 0 to 6 raise the result enable. Codes 2 to 8 raise the T enable. Only code 8 raises the Q/M enable. Codes 0 and 1 leave T untouched.
- R10: Codes 9 to 15 give in_a as the result, raise no enable and present in_t, in_q and in_m unchanged.
- R11: Every output reflects the operation presented on the previous clock edge. When in_vld is low at that edge, all three enables are low.
- R12: Synchronous active-high reset drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operation valid |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | Data / dividend operand |
| in_b | input | 32 | Shift control / compare / divisor operand |
| in_t | input | 1 | Current T flag |
| in_q | input | 1 | Current Q flag |
| in_m | input | 1 | Current M flag |
| out_res | output | 32 | Registered result |
| out_res_we | output | 1 | Result write enable |
| out_t | output | 1 | New T flag |
| out_t_we | output | 1 | T write enable |
| out_q | output | 1 | New Q flag |
| out_m | output | 1 | New M flag |
| out_qm_we | output | 1 | Q and M write enable |

## Verification
The properties assume that in_vld, in_op, the operands and the incoming flags have known values at each rising edge outside reset. They also assume that the operation sampled at one edge is the one whose outputs appear at the next edge, with no stall in between. The stimulus meets both conditions. It changes the inputs only on the falling edge, holds in_vld low with zero operands throughout reset, and presents a new fully defined operation every cycle. That operation is either a directed corner case or a random code with shift controls biased toward negative and zero distances.

// File: rtl/shflag_pkg.sv
package shflag_pkg;

    typedef enum logic [3:0] {
        OP_SHAD = 4'd0,
        OP_SHLD = 4'd1,
        OP_ROTL = 4'd2,
        OP_ROTR = 4'd3,
        OP_SHAL = 4'd4,
        OP_SHAR = 4'd5,
        OP_SHLR = 4'd6,
        OP_CMPB = 4'd7,
        OP_DIVS = 4'd8
    } op_e;

    typedef struct packed {
        logic t;
        logic t_we;
        logic q;
        logic m;
        logic qm_we;
    } flag_upd_t;

    function automatic logic writes_result(input op_e op);
        return (op == OP_SHAD) || (op == OP_SHLD) || (op == OP_ROTL) ||
               (op == OP_ROTR) || (op == OP_SHAL) || (op == OP_SHAR) ||
               (op == OP_SHLR);
    endfunction

    function automatic logic is_single_bit(input op_e op);
        return (op == OP_ROTL) || (op == OP_ROTR) || (op == OP_SHAL) ||
               (op == OP_SHAR) || (op == OP_SHLR);
    endfunction

endpackage

// File: rtl/shflag_dyn_shift.sv
module shflag_dyn_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0]         data,
    input  logic                 amt_neg,
    input  logic [$clog2(W)-1:0] amt_k,
    input  logic                 arith,
    output logic [W-1:0]         y
);
    localparam int SHW = $clog2(W);

    logic [SHW:0] rdist;

    // Right distance is the two's complement of the low field: W - k.
    assign rdist = (SHW+1)'(W) - {1'b0, amt_k};

    always_comb begin
        if (!amt_neg) begin
            y = data << amt_k;
        end else if (amt_k == '0) begin
            y = arith ? {W{data[W-1]}} : '0;
        end else if (arith) begin
            y = W'($signed(data) >>> rdist);
        end else begin
            y = data >> rdist;
        end
    end
endmodule

// File: rtl/shflag_bit_shift.sv
module shflag_bit_shift
    import shflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] data,
    input  logic         t_in,
    input  op_e          op,
    output logic [W-1:0] y,
    output logic         t_new
);
    always_comb begin
        y     = data;
        t_new = t_in;
        unique case (op)
            OP_ROTL: begin y = {data[W-2:0], t_in};  t_new = data[W-1]; end
            OP_ROTR: begin y = {t_in, data[W-1:1]};  t_new = data[0];   end
            OP_SHAL: begin y = {data[W-2:0], 1'b0};  t_new = data[W-1]; end
            OP_SHAR: begin y = {data[W-1], data[W-1:1]}; t_new = data[0]; end
            OP_SHLR: begin y = {1'b0, data[W-1:1]};  t_new = data[0];   end
            default: begin y = data; t_new = t_in; end
        endcase
    end
endmodule

// File: rtl/shflag_lane_cmp.sv
module shflag_lane_cmp #(
    parameter int W    = 32,
    parameter int LANE = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         any_eq
);
    localparam int NL = W / LANE;

    logic [NL-1:0] hit;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign hit[g] = (a[g*LANE +: LANE] == b[g*LANE +: LANE]);
    end

    assign any_eq = |hit;
endmodule

// File: rtl/shflag_unit.sv
module shflag_unit
    import shflag_pkg::*;
#(
    parameter int W    = 32,
    parameter int LANE = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [3:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         in_t,
    input  logic         in_q,
    input  logic         in_m,
    output logic [W-1:0] out_res,
    output logic         out_res_we,
    output logic         out_t,
    output logic         out_t_we,
    output logic         out_q,
    output logic         out_m,
    output logic         out_qm_we
);
    localparam int SHW = $clog2(W);

    op_e         op;
    logic [W-1:0] dyn_y, bit_y, res_c;
    logic         bit_t, lane_eq, res_we_c;
    flag_upd_t    fl_c;

    assign op = op_e'(in_op);

    shflag_dyn_shift #(.W(W)) u_dyn (
        .data    (in_a),
        .amt_neg (in_b[W-1]),
        .amt_k   (in_b[SHW-1:0]),
        .arith   (op == OP_SHAD),
        .y       (dyn_y)
    );

    shflag_bit_shift #(.W(W)) u_bit (
        .data  (in_a),
        .t_in  (in_t),
        .op    (op),
        .y     (bit_y),
        .t_new (bit_t)
    );

    shflag_lane_cmp #(.W(W), .LANE(LANE)) u_cmp (
        .a      (in_a),
        .b      (in_b),
        .any_eq (lane_eq)
    );

    always_comb begin
        res_c    = in_a;
        res_we_c = writes_result(op);
        fl_c     = '{t: in_t, t_we: 1'b0, q: in_q, m: in_m, qm_we: 1'b0};
        if (op == OP_SHAD || op == OP_SHLD) begin
            res_c = dyn_y;
        end else if (is_single_bit(op)) begin
            res_c     = bit_y;
            fl_c.t    = bit_t;
            fl_c.t_we = 1'b1;
        end else if (op == OP_CMPB) begin
            fl_c.t    = lane_eq;
            fl_c.t_we = 1'b1;
        end else if (op == OP_DIVS) begin
            fl_c.q     = in_b[W-1];
            fl_c.m     = in_a[W-1];
            fl_c.t     = in_b[W-1] ^ in_a[W-1];
            fl_c.t_we  = 1'b1;
            fl_c.qm_we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_res    <= '0;
            out_res_we <= 1'b0;
            out_t      <= 1'b0;
            out_t_we   <= 1'b0;
            out_q      <= 1'b0;
            out_m      <= 1'b0;
            out_qm_we  <= 1'b0;
        end else begin
            out_res    <= res_c;
            out_res_we <= in_vld & res_we_c;
            out_t      <= fl_c.t;
            out_t_we   <= in_vld & fl_c.t_we;
            out_q      <= fl_c.q;
            out_m      <= fl_c.m;
            out_qm_we  <= in_vld & fl_c.qm_we;
        end
    end
endmodule

// File: rtl/shflag_unit_chk.sv
module shflag_unit_chk
    import shflag_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_vld,
    input logic [3:0]   in_op,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         in_t,
    input logic         out_res_we,
    input logic [W-1:0] out_res,
    input logic         out_t,
    input logic         out_t_we,
    input logic         out_q,
    input logic         out_m,
    input logic         out_qm_we
);
    localparam int SHW = $clog2(W);

    p_dyn_left_r1: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == OP_SHAD && !in_b[W-1])
        |=> out_res == $past(in_a << in_b[SHW-1:0]));

    p_neg_zero_arith_r3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == OP_SHAD && in_b[W-1] && in_b[SHW-1:0] == '0)
        |=> out_res == {W{$past(in_a[W-1])}});

    p_neg_zero_logic_r3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == OP_SHLD && in_b[W-1] && in_b[SHW-1:0] == '0)
        |=> out_res == '0);

    p_rotl_r5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == OP_ROTL)
        |=> out_t == $past(in_a[W-1]) && out_res[0] == $past(in_t));

    p_shar_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == OP_SHAR)
        |=> out_res[W-1] == $past(in_a[W-1]) && out_t == $past(in_a[0]));

    p_byte_all_eq_r7: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == OP_CMPB && in_a == in_b)
        |=> out_t && out_t_we && !out_res_we);

    p_div_flags_r8: assert property (@(posedge clk) disable iff (rst)
        out_qm_we |-> out_t_we && (out_t == (out_q ^ out_m)));

    p_dyn_keeps_t_r9: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (in_op == OP_SHAD || in_op == OP_SHLD))
        |=> out_res_we && !out_t_we && !out_qm_we);

    p_unused_r10: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op >= 4'd9)
        |=> !out_res_we && !out_t_we && !out_qm_we && out_res == $past(in_a));

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_res_we && !out_t_we && !out_qm_we);
endmodule

bind shflag_unit shflag_unit_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (in_vld),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .in_t       (in_t),
    .out_res_we (out_res_we),
    .out_res    (out_res),
    .out_t      (out_t),
    .out_t_we   (out_t_we),
    .out_q      (out_q),
    .out_m      (out_m),
    .out_qm_we  (out_qm_we)
);

// File: tb/shflag_unit_test.sv
`timescale 1ns/1ps
module shflag_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [3:0]  in_op;
    logic [31:0] in_a, in_b;
    logic        in_t, in_q, in_m;
    logic [31:0] out_res;
    logic        out_res_we, out_t, out_t_we, out_q, out_m, out_qm_we;

    int checks = 0;
    int errors = 0;

    logic [37:0] exp_v;
    string       exp_tag;

    always #2.5 clk = ~clk;

    shflag_unit uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_t(in_t), .in_q(in_q), .in_m(in_m),
        .out_res(out_res), .out_res_we(out_res_we), .out_t(out_t),
        .out_t_we(out_t_we), .out_q(out_q), .out_m(out_m), .out_qm_we(out_qm_we)
    );

    // Behavioural reference: computes the expected outputs for one operation.
    task automatic model(input logic v, input int op, input logic [31:0] a,
                         input logic [31:0] b, input logic t, input logic q,
                         input logic m);
        logic [31:0] r;
        logic        rwe, nt, twe, nq, nm, qmwe;
        int          k, s, idx;
        string       tag;
        r = a; nt = t; nq = q; nm = m; rwe = 0; twe = 0; qmwe = 0;
        k = int'(b[4:0]);
        tag = "R10";
        case (op)
            0, 1: begin
                rwe = 1;
                if (!b[31]) begin
                    r = a << k; tag = "R1";
                end else begin
                    s = (k == 0) ? 32 : 32 - k;
                    for (int i = 0; i < 32; i++) begin
                        idx = i + s;
                        r[i] = (idx < 32) ? a[idx] : ((op == 0) ? a[31] : 1'b0);
                    end
                    tag = (k == 0) ? "R3" : ((op == 0) ? "R2" : "R4");
                end
            end
            2: begin r = {a[30:0], t}; nt = a[31]; rwe = 1; twe = 1; tag = "R5"; end
            3: begin r = {t, a[31:1]}; nt = a[0];  rwe = 1; twe = 1; tag = "R5"; end
            4: begin r = a * 2;        nt = a[31]; rwe = 1; twe = 1; tag = "R6"; end
            5: begin r = {a[31], a[31:1]}; nt = a[0]; rwe = 1; twe = 1; tag = "R6"; end
            6: begin r = a / 2;        nt = a[0];  rwe = 1; twe = 1; tag = "R6"; end
            7: begin
                nt = 0;
                for (int l = 0; l < 4; l++)
                    if (a[l*8 +: 8] == b[l*8 +: 8]) nt = 1;
                twe = 1; tag = "R7";
            end
            8: begin
                nq = b[31]; nm = a[31]; nt = nq ^ nm; twe = 1; qmwe = 1; tag = "R8";
            end
            default: ;
        endcase
        if (!v) tag = "R11";
        exp_v   = {r, rwe & v, nt, twe & v, nq, nm, qmwe & v};
        exp_tag = {tag, " R9"};
    endtask

    task automatic check_out();
        logic [37:0] act;
        act = {out_res, out_res_we, out_t, out_t_we, out_q, out_m, out_qm_we};
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", exp_tag, act, exp_v);
        end
    endtask

    task automatic step(input logic v, input int op, input logic [31:0] a,
                        input logic [31:0] b, input logic t, input logic q,
                        input logic m);
        @(negedge clk);
        check_out();
        in_vld = v; in_op = 4'(op); in_a = a; in_b = b;
        in_t = t; in_q = q; in_m = m;
        model(v, op, a, b, t, q, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; in_vld = 0; in_op = 0; in_a = 0; in_b = 0;
        in_t = 0; in_q = 0; in_m = 0;
        exp_v = '0; exp_tag = "R12";
        repeat (3) @(negedge clk);
        check_out();                                   // R12 reset state
        rst = 0;
        // R1 left shifts
        step(1, 0, 32'h8000_0001, 32'h0000_0004, 0, 0, 0);
        step(1, 1, 32'hDEAD_BEEF, 32'h0000_001F, 1, 0, 0);
        // R2 arithmetic right, k=31 -> 1, k=1 -> 31
        step(1, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0);
        step(1, 0, 32'hF000_0000, 32'h8000_0001, 0, 0, 0);
        // R3 full-width right
        step(1, 0, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
        step(1, 0, 32'h7FFF_FFFF, 32'hFFFF_FFE0, 0, 0, 0);
        step(1, 1, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 0);
        // R4 logical right
        step(1, 1, 32'hF000_0000, 32'hFFFF_FFFC, 1, 0, 0);
        // R5 rotates with both T values
        step(1, 2, 32'h8000_0000, 32'h0, 1, 0, 0);
        step(1, 2, 32'h0000_0001, 32'h0, 0, 0, 0);
        step(1, 3, 32'h0000_0001, 32'h0, 0, 0, 0);
        step(1, 3, 32'h0000_0002, 32'h0, 1, 0, 0);
        // R6 single-bit shifts
        step(1, 4, 32'hC000_0001, 32'h0, 0, 0, 0);
        step(1, 5, 32'h8000_0003, 32'h0, 0, 0, 0);
        step(1, 6, 32'h8000_0003, 32'h0, 1, 0, 0);
        // R7 each lane alone, none
        step(1, 7, 32'h1122_3344, 32'hAABB_CC44, 0, 0, 0);
        step(1, 7, 32'h1122_3344, 32'hAABB_33CC, 0, 0, 0);
        step(1, 7, 32'h1122_3344, 32'hAA22_CCDD, 0, 0, 0);
        step(1, 7, 32'h1122_3344, 32'h11BB_CCDD, 0, 0, 0);
        step(1, 7, 32'h1122_3344, 32'h2233_4455, 1, 0, 0);
        // R8 all sign combinations
        step(1, 8, 32'h0, 32'h0, 1, 1, 1);
        step(1, 8, 32'h8000_0000, 32'h0, 0, 0, 0);
        step(1, 8, 32'h0, 32'h8000_0000, 0, 0, 1);
        step(1, 8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0);
        // R10 unused codes
        step(1, 9, 32'h1234_5678, 32'hFFFF_FFFF, 1, 1, 0);
        step(1, 15, 32'hCAFE_F00D, 32'h0, 0, 0, 1);
        // R11 idle cycle
        step(0, 2, 32'h8000_0000, 32'h0, 1, 0, 0);
        step(0, 8, 32'h8000_0000, 32'h0, 0, 0, 0);
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (n % 5 == 0) rb[4:0] = 5'd0;
            if (n % 3 == 0) rb[31] = 1'b1;
            step(($urandom % 8) != 0, int'($urandom % 16), ra, rb,
                 1'($urandom), 1'($urandom), 1'($urandom));
        end
        @(negedge clk);
        check_out();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule